// File: doc/BRIEF.md
# Boot Shadow Copy Controller

This block runs from power-up, before the processor may fetch anything. While it works it keeps the processor in reset and owns the RAM write port. It reads a slow parallel ROM one byte at a time, holding each address for a fixed number of wait cycles so the ROM has time to answer. Each byte goes into fast static RAM at a fixed base address. The number of wait cycles, the number of bytes and the RAM base are parameters.

After the last byte it first stops driving the ROM: the enable drops and the address lines go quiet. One cycle later it hands the RAM port back and lets the processor out of reset. From then on it watches the processor's address and read/write line and masks the RAM write strobe for any write that lands in the shadowed window, so the copy behaves as read-only memory. Reads and writes elsewhere pass through unchanged. A synchronous reset at any time, including after the hand-over, starts the whole copy again.

Top module: `boot_shadow_ctrl`

## Requirements
- R1: While reset is low and during the whole copy, `cpu_rst_n` is 0, `bus_grant` is 1 and `done` is 0. No RAM write (`ram_we` = 1) ever happens while `cpu_rst_n` is 1.
- R2: For each byte, `rom_en` stays at 1 for exactly WAIT_CYC+1 consecutive cycles with `rom_addr` held steady. The data is taken at the end of that window, so a ROM that needs WAIT_CYC+1 cycles of enable returns correct data.
- R3: The byte at ROM address i (0 to COPY_LEN-1) is written exactly once to RAM address SHADOW_BASE+i. Writes come in ascending i order, with `ram_we` high for one cycle per byte.
- R4: Each byte takes WAIT_CYC+3 cycles. `done` is first seen high after COPY_LEN*(WAIT_CYC+3)+2 rising edges, counted from the first edge at which reset is high.
- R5: `rom_en` and the ROM address drivers (`rom_drive`) are 0, and `rom_addr` is 0, for at least one cycle before `cpu_rst_n` rises. After the hand-over, `bus_grant` is 0, `done` is 1 and the ROM port stays idle.
- R6: After the hand-over, `cpu_we_out` is 0 whenever `cpu_rwb` is 0 and the full-width `cpu_addr` is in [SHADOW_BASE, SHADOW_BASE+COPY_LEN-1], including both ends of the window.
- R7: After the hand-over, `cpu_we_out` equals `cpu_we_req` for addresses outside the window (in any bank) and for any access with `cpu_rwb` = 1.
- R8: Before the hand-over, `cpu_we_out` is 0 whatever the processor-side inputs are.
- R9: Taking reset low after the hand-over puts the processor back in reset and reclaims the bus. When reset is released, the full copy runs again with the R3 and R4 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the copy |
| rom_addr | output | ROM_AW | ROM byte address, 0 when released |
| rom_data | input | DATA_W | ROM read data |
| rom_en | output | 1 | ROM chip/output enable, high while a read is in progress |
| rom_drive | output | 1 | Enables the ROM address drivers; low once the ROM is off the bus |
| ram_addr | output | CPU_AW | RAM address for copy writes |
| ram_wdata | output | DATA_W | RAM write data for copy writes |
| ram_we | output | 1 | RAM write strobe for copy writes |
| bus_grant | output | 1 | 1 while this block owns the RAM port |
| cpu_rst_n | output | 1 | Processor reset, active low |
| done | output | 1 | Copy finished and processor running |
| cpu_addr | input | CPU_AW | Processor address |
| cpu_rwb | input | 1 | Processor read/write line, 0 for write |
| cpu_we_req | input | 1 | RAM write strobe from system glue |
| cpu_we_out | output | 1 | Gated RAM write strobe |

## Verification
The assertions assume reset is held low for at least one clock before any check counts. They also assume the processor-side inputs change only between clock edges. The bench drives reset at falling edges and holds it for several cycles, and it changes processor-side inputs only on falling edges. The ROM model returns its data only after the enable has been high for WAIT_CYC+1 sampled cycles and returns a marker byte before that, so a read taken too early shows up as wrong RAM contents. Write-gating probes cover both ends of the window, a neighbour on each side, and an address that aliases the window in another bank.

// File: rtl/shadow_pkg.sv
// Package: shared state encoding for the boot shadow controller.
// Assumes: nothing; types only.
package shadow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ_ROM  = 3'd1,
        ST_WRITE_RAM = 3'd2,
        ST_NEXT      = 3'd3,
        ST_RELEASE   = 3'd4,
        ST_RUN       = 3'd5
    } shadow_state_e;

endpackage

// File: rtl/shadow_wait_timer.sv
// Module: shadow_wait_timer
// Counts the cycles the ROM enable has been held. expired rises once
// WAIT_CYC cycles have elapsed inside the current read window.
// Assumes: run stays high for the whole window and drops between reads.
module shadow_wait_timer #(
    parameter int unsigned WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(WAIT_CYC + 2);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CW'(WAIT_CYC));

    // Window counter: cleared outside a read, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_HOLDS_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && expired) |=> (!run || expired)) else $error("timer left limit"); // R2

endmodule

// File: rtl/shadow_copy_fsm.sv
// Module: shadow_copy_fsm
// Sequencer for the copy: read a ROM byte, write it to RAM, step the
// index, and after the last byte release the ROM and then start the CPU.
// Assumes: wait_done comes from a timer that runs only in ST_READ_ROM.
module shadow_copy_fsm
    import shadow_pkg::*;
#(
    parameter int unsigned COPY_LEN = 65536,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IDX_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_done,
    input  logic [DATA_W-1:0] rom_rdata,
    output shadow_state_e     state,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] byte_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COPY_LEN - 1);

    shadow_state_e state_d;
    logic          at_last;

    assign at_last = (idx == LAST_IDX);

    // Next-state selection.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:      state_d = ST_READ_ROM;
            ST_READ_ROM:  if (wait_done) state_d = ST_WRITE_RAM;
            ST_WRITE_RAM: state_d = ST_NEXT;
            ST_NEXT:      state_d = at_last ? ST_RELEASE : ST_READ_ROM;
            ST_RELEASE:   state_d = ST_RUN;
            ST_RUN:       state_d = ST_RUN;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Byte index: advances only in ST_NEXT before the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (state == ST_NEXT && !at_last) begin
            idx <= idx + 1'b1;
        end
    end

    // Read-data latch: captured at the end of the wait window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (state == ST_READ_ROM && wait_done) begin
            byte_q <= rom_rdata;
        end
    end

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE_RAM) |-> ($past(state) == ST_READ_ROM)) else $error("write without read"); // R2
    AST_ADDR_STEADY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_ROM && $past(state) == ST_READ_ROM) |-> $stable(idx)) else $error("address moved"); // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX) else $error("index overran"); // R3

endmodule

// File: rtl/shadow_write_guard.sv
// Module: shadow_write_guard
// Gates the RAM write strobe coming from the system. Before it is armed,
// nothing passes. Once armed, writes (rwb low) into the shadow window are
// masked and everything else passes.
// Assumes: the address is the full processor address, bank included.
module shadow_write_guard #(
    parameter int unsigned CPU_AW      = 24,
    parameter int unsigned SHADOW_BASE = 0,
    parameter int unsigned COPY_LEN    = 65536
) (
    input  logic              armed,
    input  logic              we_req,
    input  logic              rwb,
    input  logic [CPU_AW-1:0] addr,
    output logic              we_out
);
    localparam logic [CPU_AW:0] WIN_LO = (CPU_AW+1)'(SHADOW_BASE);
    localparam logic [CPU_AW:0] WIN_HI = (CPU_AW+1)'(SHADOW_BASE + COPY_LEN);

    logic in_window;
    logic blocked;

    // Window decode and strobe mask.
    always_comb begin
        in_window = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
        blocked   = !armed || (!rwb && in_window);
        we_out    = we_req && !blocked;
    end

    always_comb begin
        AST_READ_PASSES: assert (!(armed && rwb && we_req) || we_out) else $error("read masked"); // R7
    end

endmodule

// File: rtl/boot_shadow_ctrl.sv
// Module: boot_shadow_ctrl (top)
// Copies COPY_LEN bytes from a slow ROM into RAM at SHADOW_BASE while the
// CPU is held in reset. It then releases the ROM, starts the CPU, and
// write-protects the shadow window.
// Assumes: rst_n is synchronous and held low at least one clock at power-up;
// external glue muxes the RAM port with the CPU using bus_grant.
module boot_shadow_ctrl
    import shadow_pkg::*;
#(
    parameter int unsigned CPU_AW      = 24,
    parameter int unsigned ROM_AW      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned COPY_LEN    = 65536,
    parameter int unsigned WAIT_CYC    = 3,
    parameter int unsigned SHADOW_BASE = 32'h0001_0000 - COPY_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic              rom_en,
    output logic              rom_drive,
    output logic [CPU_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              bus_grant,
    output logic              cpu_rst_n,
    output logic              done,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rwb,
    input  logic              cpu_we_req,
    output logic              cpu_we_out
);
    localparam int unsigned IDX_W = (COPY_LEN > 1) ? $clog2(COPY_LEN) : 1;
    localparam logic [CPU_AW:0] RAM_LO = (CPU_AW+1)'(SHADOW_BASE);
    localparam logic [CPU_AW:0] RAM_HI = (CPU_AW+1)'(SHADOW_BASE + COPY_LEN);

    shadow_state_e     state;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] byte_q;
    logic              wait_done;
    logic              in_read;
    logic              running;

    assign in_read = (state == ST_READ_ROM);
    assign running = (state == ST_RUN);

    shadow_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_read),
        .expired (wait_done)
    );

    shadow_copy_fsm #(
        .COPY_LEN (COPY_LEN),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_done (wait_done),
        .rom_rdata (rom_data),
        .state     (state),
        .idx       (idx),
        .byte_q    (byte_q)
    );

    shadow_write_guard #(
        .CPU_AW      (CPU_AW),
        .SHADOW_BASE (SHADOW_BASE),
        .COPY_LEN    (COPY_LEN)
    ) u_guard (
        .armed  (running),
        .we_req (cpu_we_req),
        .rwb    (cpu_rwb),
        .addr   (cpu_addr),
        .we_out (cpu_we_out)
    );

    // Port decode from sequencer state.
    always_comb begin
        rom_drive = (state == ST_READ_ROM) || (state == ST_WRITE_RAM) || (state == ST_NEXT);
        rom_en    = in_read;
        rom_addr  = rom_drive ? ROM_AW'(idx) : '0;
        ram_we    = (state == ST_WRITE_RAM);
        ram_addr  = CPU_AW'(SHADOW_BASE) + CPU_AW'(idx);
        ram_wdata = byte_q;
        bus_grant = !running;
        cpu_rst_n = running;
        done      = running;
    end

    AST_CPU_HELD_IN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || rom_en) |-> !cpu_rst_n) else $error("cpu free during copy"); // R1
    AST_COPY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (({1'b0, ram_addr} >= RAM_LO) && ({1'b0, ram_addr} < RAM_HI))) else $error("copy outside window"); // R3
    AST_ROM_IDLE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |-> (!rom_en && !rom_drive && rom_addr == '0)) else $error("rom active in run"); // R5
    AST_RELEASE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past(!rom_drive && !rom_en && bus_grant)) else $error("start before release"); // R5
    AST_NO_WRITE_PRE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rst_n |-> !cpu_we_out) else $error("write passed before run"); // R8

endmodule

// File: tb/boot_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module boot_shadow_ctrl_bench;
    localparam int LEN  = 16;
    localparam int WAIT = 3;
    localparam int AW   = 24;
    localparam int RAW  = 16;
    localparam int DW   = 8;
    localparam int BASE = 32'h0001_0000 - LEN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [RAW-1:0] rom_addr;
    logic [DW-1:0]  rom_data;
    logic rom_en, rom_drive;
    logic [AW-1:0]  ram_addr;
    logic [DW-1:0]  ram_wdata;
    logic ram_we, bus_grant, cpu_rst_n, done;
    logic [AW-1:0]  cpu_addr = '0;
    logic cpu_rwb = 1'b1;
    logic cpu_we_req = 1'b0;
    logic cpu_we_out;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    boot_shadow_ctrl #(
        .CPU_AW(AW), .ROM_AW(RAW), .DATA_W(DW),
        .COPY_LEN(LEN), .WAIT_CYC(WAIT), .SHADOW_BASE(BASE)
    ) u_boot_shadow_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rom_addr(rom_addr), .rom_data(rom_data), .rom_en(rom_en), .rom_drive(rom_drive),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .bus_grant(bus_grant), .cpu_rst_n(cpu_rst_n), .done(done),
        .cpu_addr(cpu_addr), .cpu_rwb(cpu_rwb), .cpu_we_req(cpu_we_req), .cpu_we_out(cpu_we_out)
    );

    function automatic logic [7:0] rom_byte(input int a);
        return 8'(a * 5 + 17);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slow ROM model: data valid only after WAIT+1 sampled cycles of enable.
    int age = 0;
    assign rom_data = (rom_en && age >= WAIT + 1) ? rom_byte(int'(rom_addr)) : 8'hEE;

    // RAM image and order/handover monitors, sampled at the falling edge.
    logic [7:0] ram_img [LEN];
    int wr_count = 0;
    int next_idx = 0;
    int off;
    int en_len = 0;
    logic prev_cpu = 1'b0, prev_drive = 1'b0, prev_en = 1'b0;

    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            off = int'(ram_addr) - BASE;
            chk("R3 write order", off, next_idx);
            chk("R1 cpu held on write", int'(cpu_rst_n), 0);
            if (off >= 0 && off < LEN) ram_img[off] = ram_wdata;
            wr_count++;
            next_idx++;
        end
        if (rst_n && !prev_cpu && cpu_rst_n) begin
            chk("R5 rom released first", int'(prev_drive | prev_en), 0);
        end
        if (rom_en) en_len++;
        else if (en_len != 0) begin
            chk("R2 enable width", en_len, WAIT + 1);
            en_len = 0;
        end
        prev_cpu   = cpu_rst_n;
        prev_drive = rom_drive;
        prev_en    = rom_en;
        age = rom_en ? age + 1 : 0;
    end

    task automatic clear_img();
        for (int i = 0; i < LEN; i++) ram_img[i] = 8'h00;
        wr_count = 0;
        next_idx = 0;
    endtask

    // Release reset, probe the write gate mid-copy, and time the copy.
    task automatic boot_and_time(input string tag);
        int n;
        n = 0;
        clear_img();
        @(negedge clk) rst_n = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (n == 10) begin
                chk("R1 cpu held mid-copy", int'(cpu_rst_n), 0);
                chk("R1 bus owned mid-copy", int'(bus_grant), 1);
                cpu_addr = 24'h000100; cpu_rwb = 1'b0; cpu_we_req = 1'b1;
                #1 chk("R8 strobe blocked before run", int'(cpu_we_out), 0);
                cpu_rwb = 1'b1;
                #1 chk("R8 read strobe blocked before run", int'(cpu_we_out), 0);
                cpu_we_req = 1'b0;
            end
        end while (!done && n < 1000);
        chk({tag, " copy cycles"}, n, LEN * (WAIT + 3) + 2);
        chk({tag, " write count"}, wr_count, LEN);
        for (int i = 0; i < LEN; i++) chk({tag, " shadow byte"}, int'(ram_img[i]), int'(rom_byte(i)));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset cpu_rst_n", int'(cpu_rst_n), 0);
        chk("R1 reset bus_grant", int'(bus_grant), 1);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset ram_we", int'(ram_we), 0);
        chk("R1 reset rom_en", int'(rom_en), 0);
    endtask

    task automatic t_copy();
        boot_and_time("R4");
        chk("R5 run bus_grant", int'(bus_grant), 0);
        chk("R5 run cpu_rst_n", int'(cpu_rst_n), 1);
        chk("R5 run rom_en", int'(rom_en), 0);
        chk("R5 run rom_drive", int'(rom_drive), 0);
        chk("R5 run rom_addr", int'(rom_addr), 0);
        repeat (4) @(negedge clk);
        chk("R5 run stays done", int'(done), 1);
        chk("R3 no extra writes", wr_count, LEN);
    endtask

    task automatic probe(input string req, input int a, input logic rwb, input logic req_in, input int exp);
        @(negedge clk);
        cpu_addr = AW'(a); cpu_rwb = rwb; cpu_we_req = req_in;
        #1 chk(req, int'(cpu_we_out), exp);
    endtask

    task automatic t_guard();
        probe("R6 window low end", BASE, 1'b0, 1'b1, 0);
        probe("R6 window high end", BASE + LEN - 1, 1'b0, 1'b1, 0);
        probe("R6 window middle", BASE + 7, 1'b0, 1'b1, 0);
        probe("R7 just below window", BASE - 1, 1'b0, 1'b1, 1);
        probe("R7 next bank start", BASE + LEN, 1'b0, 1'b1, 1);
        probe("R7 aliased bank", 32'h0001_0000 + BASE, 1'b0, 1'b1, 1);
        probe("R7 read in window", BASE + 3, 1'b1, 1'b1, 1);
        probe("R7 no request", BASE - 1, 1'b0, 1'b0, 0);
        @(negedge clk);
        cpu_we_req = 1'b0; cpu_rwb = 1'b1;
    endtask

    task automatic t_restart();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 cpu back in reset", int'(cpu_rst_n), 0);
        chk("R9 bus reclaimed", int'(bus_grant), 1);
        chk("R9 done cleared", int'(done), 0);
        boot_and_time("R9");
    endtask

    initial begin
        t_reset();
        t_copy();
        t_guard();
        t_restart();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule